// File: doc/BRIEF.md
# Decision-Directed Half-Burst Correlator

This block takes a burst of complex baseband samples that have already passed a coarse frequency and phase correction. It runs at one sample per clock and estimates what offset is left. For each sample it makes a hard symbol decision: binary phase keying uses the sign of the in-phase part, and quadrature phase keying uses both signs. It then multiplies the sample by the complex conjugate of that decision, which removes the modulation. The results are summed separately over the first half and the second half of the burst.

When the last sample has been taken in, the block presents both half sums, the product of the first sum with the conjugate of the second, and the total of the two sums. The argument of the product measures the phase drift between the two halves, which gives the residual frequency. The argument of the total gives the residual phase. The arctangent, the scaling and the final rotation of the samples are done downstream.

A start pulse opens a burst and captures its length, which is an even number from 2 to MAX_LEN. Samples then arrive with a valid strobe, and gaps between them are allowed. The estimate is only meaningful while the residual phase advance over half a burst stays below pi.

Top module: `dd_half_correlator`

## Requirements
- R1: After reset, `done` is 0 and every result output is 0.
- R2: With `qpsk_mode` = 0, the decision is d = +1 when the in-phase value is >= 0 and d = -1 otherwise. The modulation-removed sample is (I*d, Q*d), so a zero in-phase value counts as positive.
- R3: With `qpsk_mode` = 1, a = +1 when I >= 0 (else -1) and b = +1 when Q >= 0 (else -1). The removed sample is (I*a + Q*b, Q*a - I*b), which is the sample times the conjugate of (a + jb).
- R4: `burst_len` is captured at `start`. Accepted samples with index 0 to L/2-1 add into z1, and those with index L/2 to L-1 add into z2. Sums of L full-scale samples never wrap.
- R5: `xc_re` + j`xc_im` equals z1 * conj(z2), computed exactly.
- R6: `zsum_re` + j`zsum_im` equals z1 + z2.
- R7: `done` is high for exactly one cycle, three rising edges after the edge that accepts sample L-1. All result outputs change only together with `done` and hold their values in between.
- R8: `start` clears the burst in progress and begins a new one. A sample presented in the same cycle as `start` is ignored, `in_valid` is ignored outside a burst, and idle cycles inside a burst are allowed.
- R9: A new `start` may come on the cycle right after the final sample of a burst. The previous burst's results are still delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens a burst |
| qpsk_mode | input | 1 | 0 = binary phase decisions, 1 = quadrature phase decisions |
| burst_len | input | LEN_W | Burst length L, even, captured at start |
| in_valid | input | 1 | Sample strobe |
| in_i | input | SAMPLE_W | In-phase sample, signed |
| in_q | input | SAMPLE_W | Quadrature sample, signed |
| done | output | 1 | One-cycle result strobe |
| z1_re | output | ACC_W | First-half sum, real part |
| z1_im | output | ACC_W | First-half sum, imaginary part |
| z2_re | output | ACC_W | Second-half sum, real part |
| z2_im | output | ACC_W | Second-half sum, imaginary part |
| xc_re | output | XC_W | z1*conj(z2), real part |
| xc_im | output | XC_W | z1*conj(z2), imaginary part |
| zsum_re | output | ACC_W+1 | z1+z2, real part |
| zsum_im | output | ACC_W+1 | z1+z2, imaginary part |

## Verification
The assertions assume that `burst_len` is even and at least 2, and that `start` is never raised in the same cycle as a sample that is meant to be kept. The stimulus only uses even lengths from 2 to 1024. Every sample it intends to keep is given its own cycle with `start` low, and sample-plus-start collisions appear only where the test expects the sample to be dropped. Sample values include the most negative code, so the widest removed values and the widest sums are reached without going outside the signed input range.

// File: rtl/dd_corr_pkg.sv
package dd_corr_pkg;

    typedef enum logic {
        MOD_BIN  = 1'b0,
        MOD_QUAD = 1'b1
    } mod_e;

endpackage

// File: rtl/dd_burst_ctrl.sv
module dd_burst_ctrl #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    input  logic [LEN_W-1:0] burst_len,
    output logic             accept,
    output logic             in_second,
    output logic             is_last
);

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] half;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        accept    = st_q.active && in_valid && !start;
        in_second = (st_q.idx >= st_q.half);
        is_last   = (st_q.idx == st_q.len - LEN_W'(1));
        if (start) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.len    = burst_len;
            st_d.half   = burst_len >> 1;
        end else if (accept) begin
            st_d.idx = st_q.idx + LEN_W'(1);
            if (is_last) begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dd_symbol_demod.sv
module dd_symbol_demod
    import dd_corr_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int RM_W     = SAMPLE_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept,
    input  logic                       in_second,
    input  logic                       is_last,
    input  logic                       qpsk_mode,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    output logic                       rm_valid,
    output logic                       rm_second,
    output logic                       rm_last,
    output logic signed [RM_W-1:0]     rm_re,
    output logic signed [RM_W-1:0]     rm_im
);

    typedef struct packed {
        logic                   valid;
        logic                   second;
        logic                   last;
        logic signed [RM_W-1:0] re;
        logic signed [RM_W-1:0] im;
    } stage_t;

    stage_t st_d, st_q;

    logic signed [RM_W-1:0] ext_i, ext_q;
    logic signed [RM_W-1:0] i_by_a, q_by_a, i_by_b, q_by_b;
    logic                   neg_a, neg_b;
    mod_e                   mode;

    always_comb begin
        mode   = mod_e'(qpsk_mode);
        ext_i  = RM_W'(in_i);
        ext_q  = RM_W'(in_q);
        neg_a  = in_i[SAMPLE_W-1];
        neg_b  = in_q[SAMPLE_W-1];
        i_by_a = neg_a ? -ext_i : ext_i;
        q_by_a = neg_a ? -ext_q : ext_q;
        i_by_b = neg_b ? -ext_i : ext_i;
        q_by_b = neg_b ? -ext_q : ext_q;

        st_d        = st_q;
        st_d.valid  = accept;
        st_d.second = in_second;
        st_d.last   = is_last;
        if (accept) begin
            if (mode == MOD_QUAD) begin
                st_d.re = i_by_a + q_by_b;
                st_d.im = q_by_a - i_by_b;
            end else begin
                st_d.re = i_by_a;
                st_d.im = q_by_a;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rm_valid  = st_q.valid;
    assign rm_second = st_q.second;
    assign rm_last   = st_q.last;
    assign rm_re     = st_q.re;
    assign rm_im     = st_q.im;

endmodule

// File: rtl/dd_half_accum.sv
module dd_half_accum #(
    parameter int RM_W  = 14,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    rm_valid,
    input  logic                    rm_second,
    input  logic                    rm_last,
    input  logic signed [RM_W-1:0]  rm_re,
    input  logic signed [RM_W-1:0]  rm_im,
    output logic                    snap_valid,
    output logic signed [ACC_W-1:0] snap_z1_re,
    output logic signed [ACC_W-1:0] snap_z1_im,
    output logic signed [ACC_W-1:0] snap_z2_re,
    output logic signed [ACC_W-1:0] snap_z2_im
);

    typedef struct packed {
        logic signed [ACC_W-1:0] re;
        logic signed [ACC_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        cplx_t acc1;
        cplx_t acc2;
        logic  snap_v;
        cplx_t snap1;
        cplx_t snap2;
    } acc_t;

    acc_t  st_d, st_q;
    cplx_t add1, add2, sum1, sum2;

    always_comb begin
        add1 = '0;
        add2 = '0;
        if (rm_valid && !rm_second) begin
            add1.re = ACC_W'(rm_re);
            add1.im = ACC_W'(rm_im);
        end
        if (rm_valid && rm_second) begin
            add2.re = ACC_W'(rm_re);
            add2.im = ACC_W'(rm_im);
        end
        sum1.re = st_q.acc1.re + add1.re;
        sum1.im = st_q.acc1.im + add1.im;
        sum2.re = st_q.acc2.re + add2.re;
        sum2.im = st_q.acc2.im + add2.im;

        st_d        = st_q;
        st_d.acc1   = clear ? '0 : sum1;
        st_d.acc2   = clear ? '0 : sum2;
        st_d.snap_v = rm_valid && rm_last;
        if (rm_valid && rm_last) begin
            st_d.snap1 = sum1;
            st_d.snap2 = sum2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_valid = st_q.snap_v;
    assign snap_z1_re = st_q.snap1.re;
    assign snap_z1_im = st_q.snap1.im;
    assign snap_z2_re = st_q.snap2.re;
    assign snap_z2_im = st_q.snap2.im;

endmodule

// File: rtl/dd_corr_finish.sv
module dd_corr_finish #(
    parameter int ACC_W = 24,
    parameter int XC_W  = 2 * ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snap_valid,
    input  logic signed [ACC_W-1:0] snap_z1_re,
    input  logic signed [ACC_W-1:0] snap_z1_im,
    input  logic signed [ACC_W-1:0] snap_z2_re,
    input  logic signed [ACC_W-1:0] snap_z2_im,
    output logic                    done,
    output logic signed [ACC_W-1:0] z1_re,
    output logic signed [ACC_W-1:0] z1_im,
    output logic signed [ACC_W-1:0] z2_re,
    output logic signed [ACC_W-1:0] z2_im,
    output logic signed [XC_W-1:0]  xc_re,
    output logic signed [XC_W-1:0]  xc_im,
    output logic signed [ACC_W:0]   zsum_re,
    output logic signed [ACC_W:0]   zsum_im
);

    typedef struct packed {
        logic                    done;
        logic signed [ACC_W-1:0] z1r;
        logic signed [ACC_W-1:0] z1i;
        logic signed [ACC_W-1:0] z2r;
        logic signed [ACC_W-1:0] z2i;
        logic signed [XC_W-1:0]  xr;
        logic signed [XC_W-1:0]  xi;
        logic signed [ACC_W:0]   sr;
        logic signed [ACC_W:0]   si;
    } fin_t;

    fin_t st_d, st_q;
    logic signed [XC_W-1:0] a, b, c, d;

    always_comb begin
        a = XC_W'(snap_z1_re);
        b = XC_W'(snap_z1_im);
        c = XC_W'(snap_z2_re);
        d = XC_W'(snap_z2_im);

        st_d      = st_q;
        st_d.done = snap_valid;
        if (snap_valid) begin
            st_d.z1r = snap_z1_re;
            st_d.z1i = snap_z1_im;
            st_d.z2r = snap_z2_re;
            st_d.z2i = snap_z2_im;
            st_d.xr  = a * c + b * d;
            st_d.xi  = b * c - a * d;
            st_d.sr  = (ACC_W+1)'(snap_z1_re) + (ACC_W+1)'(snap_z2_re);
            st_d.si  = (ACC_W+1)'(snap_z1_im) + (ACC_W+1)'(snap_z2_im);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign z1_re   = st_q.z1r;
    assign z1_im   = st_q.z1i;
    assign z2_re   = st_q.z2r;
    assign z2_im   = st_q.z2i;
    assign xc_re   = st_q.xr;
    assign xc_im   = st_q.xi;
    assign zsum_re = st_q.sr;
    assign zsum_im = st_q.si;

endmodule

// File: rtl/dd_half_correlator.sv
module dd_half_correlator #(
    parameter int SAMPLE_W = 12,
    parameter int MAX_LEN  = 1024,
    localparam int LEN_W   = $clog2(MAX_LEN) + 1,
    localparam int RM_W    = SAMPLE_W + 2,
    localparam int ACC_W   = RM_W + $clog2(MAX_LEN),
    localparam int XC_W    = 2 * ACC_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       qpsk_mode,
    input  logic [LEN_W-1:0]           burst_len,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    output logic                       done,
    output logic signed [ACC_W-1:0]    z1_re,
    output logic signed [ACC_W-1:0]    z1_im,
    output logic signed [ACC_W-1:0]    z2_re,
    output logic signed [ACC_W-1:0]    z2_im,
    output logic signed [XC_W-1:0]     xc_re,
    output logic signed [XC_W-1:0]     xc_im,
    output logic signed [ACC_W:0]      zsum_re,
    output logic signed [ACC_W:0]      zsum_im
);

    logic                    accept, in_second, is_last;
    logic                    rm_valid, rm_second, rm_last;
    logic signed [RM_W-1:0]  rm_re, rm_im;
    logic                    snap_valid;
    logic signed [ACC_W-1:0] s1r, s1i, s2r, s2i;

    dd_burst_ctrl #(.LEN_W(LEN_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .burst_len(burst_len), .accept(accept), .in_second(in_second),
        .is_last(is_last)
    );

    dd_symbol_demod #(.SAMPLE_W(SAMPLE_W), .RM_W(RM_W)) i_demod (
        .clk(clk), .rst_n(rst_n), .accept(accept), .in_second(in_second),
        .is_last(is_last), .qpsk_mode(qpsk_mode), .in_i(in_i), .in_q(in_q),
        .rm_valid(rm_valid), .rm_second(rm_second), .rm_last(rm_last),
        .rm_re(rm_re), .rm_im(rm_im)
    );

    dd_half_accum #(.RM_W(RM_W), .ACC_W(ACC_W)) i_accum (
        .clk(clk), .rst_n(rst_n), .clear(start), .rm_valid(rm_valid),
        .rm_second(rm_second), .rm_last(rm_last), .rm_re(rm_re), .rm_im(rm_im),
        .snap_valid(snap_valid), .snap_z1_re(s1r), .snap_z1_im(s1i),
        .snap_z2_re(s2r), .snap_z2_im(s2i)
    );

    dd_corr_finish #(.ACC_W(ACC_W), .XC_W(XC_W)) i_finish (
        .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid),
        .snap_z1_re(s1r), .snap_z1_im(s1i), .snap_z2_re(s2r), .snap_z2_im(s2i),
        .done(done), .z1_re(z1_re), .z1_im(z1_im), .z2_re(z2_re), .z2_im(z2_im),
        .xc_re(xc_re), .xc_im(xc_im), .zsum_re(zsum_re), .zsum_im(zsum_im)
    );

endmodule

// File: rtl/dd_half_correlator_chk.sv
module dd_half_correlator_chk #(
    parameter int RM_W  = 14,
    parameter int ACC_W = 24,
    parameter int XC_W  = 49
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    accept,
    input logic                    rm_valid,
    input logic signed [RM_W-1:0]  rm_re,
    input logic                    done,
    input logic signed [ACC_W-1:0] z1_re,
    input logic signed [ACC_W-1:0] z2_re,
    input logic signed [XC_W-1:0]  xc_re,
    input logic signed [ACC_W:0]   zsum_re
);

    // R2 and R3: the decision always turns the real part of the removed sample non-negative
    assert_removed_real_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rm_valid |-> rm_re >= 0);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(accept, 3));

    assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(z1_re) && $stable(z2_re) && $stable(xc_re) && $stable(zsum_re)));

    assert_start_drops_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !accept);

endmodule

bind dd_half_correlator dd_half_correlator_chk #(
    .RM_W(RM_W), .ACC_W(ACC_W), .XC_W(XC_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .rm_valid(rm_valid), .rm_re(rm_re), .done(done), .z1_re(z1_re),
    .z2_re(z2_re), .xc_re(xc_re), .zsum_re(zsum_re)
);

// File: tb/test_dd_half_correlator.sv
`timescale 1ns/1ps
module test_dd_half_correlator;

    localparam int SW    = 12;
    localparam int LW    = 11;
    localparam int ACC_W = 24;
    localparam int XC_W  = 49;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic qpsk_mode = 1'b0;
    logic [LW-1:0] burst_len = '0;
    logic in_valid = 1'b0;
    logic signed [SW-1:0] in_i = '0, in_q = '0;
    logic done;
    logic signed [ACC_W-1:0] z1_re, z1_im, z2_re, z2_im;
    logic signed [XC_W-1:0]  xc_re, xc_im;
    logic signed [ACC_W:0]   zsum_re, zsum_im;

    dd_half_correlator i_dd_half_correlator (
        .clk(clk), .rst_n(rst_n), .start(start), .qpsk_mode(qpsk_mode),
        .burst_len(burst_len), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .done(done), .z1_re(z1_re), .z1_im(z1_im), .z2_re(z2_re), .z2_im(z2_im),
        .xc_re(xc_re), .xc_im(xc_im), .zsum_re(zsum_re), .zsum_im(zsum_im)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // result monitor
    int     res_cnt = 0;
    int     res_cyc [16];
    longint res_v [16][8];
    bit     prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) begin
                n_fail++;
                $display("FAIL R7: done high two cycles in a row at cycle %0d (actual 1, expected 0)", cyc);
            end
            if (done && res_cnt < 16) begin
                res_cyc[res_cnt] = cyc;
                res_v[res_cnt][0] = longint'(z1_re);
                res_v[res_cnt][1] = longint'(z1_im);
                res_v[res_cnt][2] = longint'(z2_re);
                res_v[res_cnt][3] = longint'(z2_im);
                res_v[res_cnt][4] = longint'(xc_re);
                res_v[res_cnt][5] = longint'(xc_im);
                res_v[res_cnt][6] = longint'(zsum_re);
                res_v[res_cnt][7] = longint'(zsum_im);
                res_cnt++;
            end
            prev_done = done;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    int     smp_i [1024];
    int     smp_q [1024];
    longint e_v [8];
    int     last_cyc;

    task automatic model(input int len, input bit qp);
        longint a1r = 0, a1i = 0, a2r = 0, a2i = 0;
        for (int k = 0; k < len; k++) begin
            longint sa = (smp_i[k] < 0) ? -1 : 1;
            longint sb = (smp_q[k] < 0) ? -1 : 1;
            longint r, m;
            if (qp) begin
                r = smp_i[k] * sa + smp_q[k] * sb;
                m = smp_q[k] * sa - smp_i[k] * sb;
            end else begin
                r = smp_i[k] * sa;
                m = smp_q[k] * sa;
            end
            if (k < len / 2) begin a1r += r; a1i += m; end
            else begin a2r += r; a2i += m; end
        end
        e_v[0] = a1r; e_v[1] = a1i; e_v[2] = a2r; e_v[3] = a2i;
        e_v[4] = a1r * a2r + a1i * a2i;
        e_v[5] = a1i * a2r - a1r * a2i;
        e_v[6] = a1r + a2r;
        e_v[7] = a1i + a2i;
    endtask

    task automatic do_start(input int len, input bit qp);
        @(negedge clk);
        start = 1'b1; burst_len = LW'(len); qpsk_mode = qp; in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // drives smp_* [0..len-1]; ends right after the last sample is set (inputs still held)
    task automatic drive_samples(input int len, input int gap_every);
        for (int k = 0; k < len; k++) begin
            if (k != 0) @(negedge clk);
            if (gap_every != 0 && k != 0 && (k % gap_every) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; in_i = SW'(smp_i[k]); in_q = SW'(smp_q[k]);
        end
        last_cyc = cyc;
    endtask

    task automatic release_inputs();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_result(input int idx, input string tag);
        string names [8] = '{"z1_re", "z1_im", "z2_re", "z2_im", "xc_re", "xc_im", "zsum_re", "zsum_im"};
        check(res_cnt > idx, {tag, " result count"}, res_cnt, idx + 1);
        if (res_cnt > idx) begin
            check(res_cyc[idx] == last_cyc + 3, {tag, " R7 done latency"}, res_cyc[idx], last_cyc + 3);
            for (int f = 0; f < 8; f++)
                check(res_v[idx][f] == e_v[f], {tag, " ", names[f]}, res_v[idx][f], e_v[f]);
        end
    endtask

    task automatic wait_idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(z1_re == 0 && z2_im == 0, "R1 sums after reset", longint'(z1_re), 0);
        check(xc_re == 0 && zsum_re == 0, "R1 products after reset", longint'(xc_re), 0);
    endtask

    task automatic t_bpsk();
        int base = res_cnt;
        int vi [8] = '{100, -200, 0, 37, -1, 512, -2048, 900};
        int vq [8] = '{-50, 70, 33, -300, 2047, -9, 11, -2048};
        for (int k = 0; k < 8; k++) begin smp_i[k] = vi[k]; smp_q[k] = vq[k]; end
        model(8, 1'b0);
        do_start(8, 1'b0);
        drive_samples(8, 0);
        release_inputs();
        wait_idle(5);
        expect_result(base, "R2 R4 R5 R6 binary burst");
        check(done == 1'b0, "R7 done cleared", done, 0);
        check(longint'(z1_re) == e_v[0], "R7 results held", longint'(z1_re), e_v[0]);
    endtask

    task automatic t_qpsk();
        int base = res_cnt;
        for (int k = 0; k < 16; k++) begin
            smp_i[k] = ((k * 37) % 41 - 20) * 50 + 3;
            smp_q[k] = ((k * 23) % 29 - 14) * 70 - 5;
        end
        model(16, 1'b1);
        do_start(16, 1'b1);
        drive_samples(16, 0);
        release_inputs();
        wait_idle(5);
        expect_result(base, "R3 R5 R6 quad burst");
    endtask

    task automatic t_min_len();
        int base = res_cnt;
        smp_i[0] = -700; smp_q[0] = 300;
        smp_i[1] = 250;  smp_q[1] = -900;
        model(2, 1'b1);
        do_start(2, 1'b1);
        drive_samples(2, 0);
        release_inputs();
        wait_idle(5);
        expect_result(base, "R4 length two");
    endtask

    task automatic t_full_scale();
        int base = res_cnt;
        for (int k = 0; k < 1024; k++) begin
            smp_i[k] = (k < 512) ? 2047 : -2048;
            smp_q[k] = (k < 512) ? -2048 : -2048;
        end
        model(1024, 1'b1);
        do_start(1024, 1'b1);
        drive_samples(1024, 0);
        release_inputs();
        wait_idle(5);
        expect_result(base, "R4 full scale length 1024");
    endtask

    task automatic t_back_to_back();
        int base = res_cnt;
        longint ea [8];
        int     lc_a;
        smp_i[0] = 400; smp_q[0] = 10; smp_i[1] = -300; smp_q[1] = 60;
        smp_i[2] = 500; smp_q[2] = -80; smp_i[3] = -250; smp_q[3] = -40;
        model(4, 1'b0);
        ea = e_v;
        do_start(4, 1'b0);
        drive_samples(4, 0);
        lc_a = last_cyc;
        // start of next burst on the very next cycle
        @(negedge clk);
        in_valid = 1'b0; start = 1'b1; burst_len = LW'(4); qpsk_mode = 1'b1;
        @(negedge clk);
        start = 1'b0;
        smp_i[0] = -1000; smp_q[0] = 200; smp_i[1] = 30; smp_q[1] = 1500;
        smp_i[2] = -90; smp_q[2] = -600; smp_i[3] = 800; smp_q[3] = 800;
        drive_samples(4, 0);
        release_inputs();
        wait_idle(5);
        model(4, 1'b1);
        begin
            longint eb [8];
            int lc_b;
            eb = e_v; lc_b = last_cyc;
            e_v = ea; last_cyc = lc_a;
            expect_result(base, "R9 first of back-to-back");
            e_v = eb; last_cyc = lc_b;
            expect_result(base + 1, "R9 second of back-to-back");
        end
    endtask

    task automatic t_ignore_restart();
        int base = res_cnt;
        // strobes outside a burst
        @(negedge clk);
        in_valid = 1'b1; in_i = 12'sd1000; in_q = 12'sd1000;
        wait_idle(3);
        in_valid = 1'b0;
        // aborted burst
        do_start(8, 1'b1);
        in_valid = 1'b1; in_i = 12'sd777; in_q = -12'sd555;
        wait_idle(3);
        // restart with a sample present on the start cycle
        start = 1'b1; burst_len = LW'(6); qpsk_mode = 1'b1;
        in_i = 12'sd1999; in_q = 12'sd1999;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            smp_i[k] = (k % 2 == 0) ? 300 + k * 10 : -400 - k * 7;
            smp_q[k] = (k % 3 == 0) ? -150 : 220 + k;
        end
        model(6, 1'b1);
        drive_samples(6, 2);
        release_inputs();
        in_valid = 1'b1; in_i = 12'sd1500; in_q = 12'sd1500;
        wait_idle(6);
        in_valid = 1'b0;
        check(res_cnt == base + 1, "R8 one result only", res_cnt, base + 1);
        expect_result(base, "R8 restart with gaps");
        check(longint'(z2_re) == e_v[2], "R8 late strobe ignored", longint'(z2_re), e_v[2]);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wait_idle(2);
        t_reset();
        t_bpsk();
        t_qpsk();
        t_min_len();
        t_full_scale();
        t_back_to_back();
        t_ignore_restart();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule